// File: doc/BRIEF.md
# Digital Frequency Acquisition Controller

This controller sets the speed code of a digitally controlled oscillator so that the oscillator runs near a rational multiple N/M of a reference clock. The oscillator output and the reference both enter as asynchronous signals. Each one is synchronised into the system clock domain, reduced to a rising-edge strobe and divided by its programmable divisor. Over a fixed window of system clock cycles the controller counts the divided oscillator ticks and the divided reference ticks. At the end of the window it makes one decision. If the oscillator count is strictly larger, it commands a slower setting. Otherwise it commands a faster one.

Acquisition always starts from the fastest code and moves down one step per decision. When the count comparison first turns, the direction reverses. After that the code alternates between the two neighbouring codes on either side of the target. The controller treats this steady alternation as coarse lock. It then raises a handoff flag so that a finer loop can take over.

Top module: `freq_acq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the speed code is 8 (the fastest of codes 0..8, where larger means faster). Locked, handoff and both command outputs are low.
- R2: Exactly one decision is made every WIN_CYCLES system clock cycles. Each decision pulses exactly one of cmd_faster or cmd_slower high for one cycle. The speed code changes only in the cycle of that pulse.
- R3: If the window's count of divided oscillator ticks exceeds its count of divided reference ticks, cmd_slower pulses and the code drops by one. At code 0 the code stays at 0.
- R4: If the oscillator count is not greater than the reference count (equal counts included), cmd_faster pulses and the code rises by one. At code 8 the code stays at 8.
- R5: For a target fref*N/M that lies between the slowest and fastest oscillator frequency, the code descends from 8. It then settles alternating between the two adjacent codes that bracket the target, and locked goes high.
- R6: A divisor of zero on either divider input behaves exactly as a divisor of one.
- R7: Locked goes high at the decision that completes four consecutive direction reversals. A decision in the same direction as the previous one clears locked.
- R8: Handoff rises together with the first assertion of locked and stays high until reset, even if locked later drops.
- R9: When the target lies above the fastest or below the slowest oscillator frequency, the code holds at 8 or 0 respectively and locked never goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | Oscillator output, asynchronous to clk |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fb_div | input | 8 | Feedback divisor N (0 acts as 1) |
| ref_div | input | 8 | Reference divisor M (0 acts as 1) |
| speed_code | output | 4 | Oscillator speed setting, 0 slowest to 8 fastest |
| cmd_faster | output | 1 | One-cycle pulse: decision to speed up |
| cmd_slower | output | 1 | One-cycle pulse: decision to slow down |
| locked | output | 1 | Coarse lock (alternation established) |
| handoff | output | 1 | Sticky flag passing fine control to another loop |

## Verification
The bench builds the block with its defaults: a 1024-cycle window, two synchroniser stages and four reversals for lock. It drives a 40 MHz reference and an oscillator model whose half period shrinks by 4 ns per code, from 40 ns at code 0. With this window, every divisor pair the bench accepts keeps the expected counts several ticks apart. Each decision is therefore predictable from the requirements alone. The descent, the bracketing alternation, saturation at both ends, divisor zero and the lock and handoff sequencing can then all be checked decision by decision.

// File: rtl/fa_pkg.sv
// Shared types for the frequency acquisition controller.
package fa_pkg;

    // Direction of one acquisition decision
    typedef enum logic {
        DIR_FASTER = 1'b0,
        DIR_SLOWER = 1'b1
    } step_dir_e;

endpackage

// File: rtl/fa_edge_div.sv
// Synchronises an asynchronous clock-like input, detects its rising edges
// and divides them by a programmable count. Emits one tick per N edges.
// Assumes the input stays high and low for at least one clk period each.
// A divisor of zero is treated as one.
module fa_edge_div #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;
    logic [DIV_W-1:0]       n_eff;
    logic [DIV_W-1:0]       cnt_q;

    // Bring the input into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
    end

    // Remember the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Rising edge strobe and effective divisor
    always_comb begin
        rise  = sync_q[SYNC_STAGES-1] & ~last_q;
        n_eff = (div_n == '0) ? DIV_W'(1) : div_n;
    end

    // Count edges and emit a tick every n_eff of them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (rise) begin
                if (cnt_q >= n_eff - DIV_W'(1)) begin
                    cnt_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + DIV_W'(1);
                end
            end
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5

endmodule

// File: rtl/fa_window_cmp.sv
// Counts divided oscillator and divided reference ticks over a fixed window
// of WIN_CYCLES clocks, then issues one decision: slower when the
// oscillator count is strictly greater, faster otherwise.
module fa_window_cmp
    import fa_pkg::*;
#(
    parameter int WIN_CYCLES = 1024,
    parameter int CNT_W      = $clog2(WIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_tick,
    input  logic ref_tick,
    output logic dec_vld,
    output logic dec_slow
);

    localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

    logic [WIN_W-1:0] win_q;
    logic             win_last;
    logic [CNT_W-1:0] fb_cnt_q;
    logic [CNT_W-1:0] ref_cnt_q;

    // Detect the final cycle of the window
    always_comb win_last = (win_q == WIN_W'(WIN_CYCLES - 1));

    // Window timer
    always_ff @(posedge clk) begin
        if (!rst_n)        win_q <= '0;
        else if (win_last) win_q <= '0;
        else               win_q <= win_q + WIN_W'(1);
    end

    // Tick counters, restarted at each window boundary without losing a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_cnt_q  <= '0;
            ref_cnt_q <= '0;
        end else if (win_last) begin
            fb_cnt_q  <= CNT_W'(fb_tick);
            ref_cnt_q <= CNT_W'(ref_tick);
        end else begin
            fb_cnt_q  <= fb_cnt_q + CNT_W'(fb_tick);
            ref_cnt_q <= ref_cnt_q + CNT_W'(ref_tick);
        end
    end

    // Register the decision at the close of the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld  <= 1'b0;
            dec_slow <= 1'b0;
        end else begin
            dec_vld  <= win_last;
            dec_slow <= win_last && (fb_cnt_q > ref_cnt_q);
        end
    end

    AST_DEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld); // R2

    AST_SLOW_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_slow |-> dec_vld); // R3

endmodule

// File: rtl/fa_step_lock.sv
// Holds the speed code, steps it by one per decision with saturation at
// both ends, tracks consecutive direction reversals to declare lock, and
// keeps a sticky handoff flag. Assumes dec_vld is a single-cycle strobe.
module fa_step_lock
    import fa_pkg::*;
#(
    parameter int CODE_MAX  = 8,
    parameter int LOCK_REVS = 4,
    parameter int CODE_W    = $clog2(CODE_MAX + 1),
    parameter int REV_W     = $clog2(LOCK_REVS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_vld,
    input  logic              dec_slow,
    output logic [CODE_W-1:0] code,
    output logic              cmd_faster,
    output logic              cmd_slower,
    output logic              locked,
    output logic              handoff
);

    step_dir_e         dec_dir;
    step_dir_e         prev_dir;
    logic              have_prev;
    logic [REV_W-1:0]  rev_q;
    logic [REV_W-1:0]  rev_next;
    logic [CODE_W-1:0] code_next;
    logic              lock_next;

    // Next code, reversal count and lock condition
    always_comb begin
        dec_dir   = dec_slow ? DIR_SLOWER : DIR_FASTER;
        code_next = code;
        rev_next  = rev_q;
        if (dec_vld) begin
            if (dec_dir == DIR_SLOWER) begin
                if (code != '0) code_next = code - CODE_W'(1);
            end else begin
                if (code != CODE_W'(CODE_MAX)) code_next = code + CODE_W'(1);
            end
            if (have_prev && (prev_dir != dec_dir))
                rev_next = (rev_q == REV_W'(LOCK_REVS)) ? rev_q : rev_q + REV_W'(1);
            else
                rev_next = '0;
        end
        lock_next = (rev_next == REV_W'(LOCK_REVS));
    end

    // State update on each decision; command pulses follow the decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code       <= CODE_W'(CODE_MAX);
            cmd_faster <= 1'b0;
            cmd_slower <= 1'b0;
            have_prev  <= 1'b0;
            prev_dir   <= DIR_SLOWER;
            rev_q      <= '0;
            locked     <= 1'b0;
            handoff    <= 1'b0;
        end else begin
            cmd_faster <= dec_vld && (dec_dir == DIR_FASTER);
            cmd_slower <= dec_vld && (dec_dir == DIR_SLOWER);
            code       <= code_next;
            rev_q      <= rev_next;
            locked     <= lock_next;
            handoff    <= handoff | lock_next;
            if (dec_vld) begin
                have_prev <= 1'b1;
                prev_dir  <= dec_dir;
            end
        end
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_slow && code != '0) |=> code == $past(code) - CODE_W'(1)); // R3
    AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_slow && code == '0) |=> code == '0); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !dec_slow && code != CODE_W'(CODE_MAX)) |=> code == $past(code) + CODE_W'(1)); // R4
    AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !dec_slow && code == CODE_W'(CODE_MAX)) |=> code == CODE_W'(CODE_MAX)); // R4
    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |=> $stable(code)); // R2
    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_faster, cmd_slower})); // R2
    AST_SAME_DIR_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && have_prev && prev_dir == dec_dir) |=> !locked); // R7
    AST_HANDOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |=> handoff); // R8
    AST_LOCK_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> handoff); // R8

endmodule

// File: rtl/freq_acq_ctrl.sv
// Top of the frequency acquisition controller: two edge dividers, a
// window comparator and the step/lock register. Oscillator and reference
// inputs are asynchronous and must be slower than half the clk rate.
module freq_acq_ctrl #(
    parameter int CODE_MAX    = 8,
    parameter int DIV_W       = 8,
    parameter int WIN_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_REVS   = 4,
    parameter int CODE_W      = $clog2(CODE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              ref_in,
    input  logic [DIV_W-1:0]  fb_div,
    input  logic [DIV_W-1:0]  ref_div,
    output logic [CODE_W-1:0] speed_code,
    output logic              cmd_faster,
    output logic              cmd_slower,
    output logic              locked,
    output logic              handoff
);

    logic fb_tick;
    logic ref_tick;
    logic dec_vld;
    logic dec_slow;

    fa_edge_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_fb_div (
        .clk(clk), .rst_n(rst_n), .sig_in(osc_in), .div_n(fb_div), .tick(fb_tick)
    );

    fa_edge_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .sig_in(ref_in), .div_n(ref_div), .tick(ref_tick)
    );

    fa_window_cmp #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk(clk), .rst_n(rst_n), .fb_tick(fb_tick), .ref_tick(ref_tick),
        .dec_vld(dec_vld), .dec_slow(dec_slow)
    );

    fa_step_lock #(.CODE_MAX(CODE_MAX), .LOCK_REVS(LOCK_REVS), .CODE_W(CODE_W)) u_step (
        .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_slow(dec_slow),
        .code(speed_code), .cmd_faster(cmd_faster), .cmd_slower(cmd_slower),
        .locked(locked), .handoff(handoff)
    );

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        speed_code <= CODE_W'(CODE_MAX)); // R1

endmodule

// File: tb/freq_acq_ctrl_tb.sv
`timescale 1ns/1ps
module freq_acq_ctrl_tb;

    localparam int WIN    = 1024;
    localparam int WDOG   = 190000;
    localparam real TCLK  = 5.0;
    localparam real FREF  = 40.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc = 1'b0;
    logic       refc = 1'b0;
    logic [7:0] fb_div = 8'd1;
    logic [7:0] ref_div = 8'd1;
    logic [3:0] speed_code;
    logic       cmd_faster, cmd_slower, locked, handoff;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    freq_acq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc), .ref_in(refc),
        .fb_div(fb_div), .ref_div(ref_div), .speed_code(speed_code),
        .cmd_faster(cmd_faster), .cmd_slower(cmd_slower),
        .locked(locked), .handoff(handoff)
    );

    always #2.5 clk = ~clk;
    always #12.5 refc = ~refc;

    // Behavioural oscillator: half period 40 ns at code 0, 4 ns less per code
    initial begin
        real hp;
        int  c;
        forever begin
            c  = $isunknown(speed_code) ? 8 : int'(speed_code);
            hp = 40.0 - 4.0 * c;
            #hp osc = ~osc;
        end
    end

    function automatic real fosc(int c);
        return 1000.0 / (80.0 - 8.0 * c);
    endfunction

    function automatic bit exp_slower(int c, int n, int m);
        int ne = (n == 0) ? 1 : n;
        int me = (m == 0) ? 1 : m;
        return (fosc(c) / ne) > (FREF / me);
    endfunction

    function automatic bit margin_ok(int n, int m);
        for (int c = 0; c <= 8; c++) begin
            real d = WIN * TCLK / 1000.0 * (fosc(c) / n - FREF / m);
            if (d < 4.0 && d > -4.0) return 0;
        end
        return 1;
    endfunction

    // Highest code that is not faster than the target, -1 if none
    function automatic int bracket_lo(int n, int m);
        int lo = -1;
        for (int c = 0; c <= 8; c++) if (!exp_slower(c, n, m)) lo = c;
        return lo;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            finish_run();
        end
    end

    task automatic run_cfg(int n, int m, int ndec);
        int prev_code = 8;
        bit have_prev = 0;
        bit prev_slow = 0;
        int rev = 0;
        bit exp_hand = 0;
        int lo;
        @(negedge clk);
        rst_n = 1'b0;
        fb_div = 8'(n);
        ref_div = 8'(m);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(speed_code == 4'd8, "R1 code", speed_code, 8);
        chk(!locked && !handoff, "R1 flags", {locked, handoff}, 0);
        chk(!cmd_faster && !cmd_slower, "R1 cmds", {cmd_faster, cmd_slower}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < ndec; k++) begin
            int  waited = 0;
            bit  es;
            int  ecode;
            do begin
                @(negedge clk);
                waited++;
            end while (!(cmd_faster || cmd_slower) && waited < 3 * WIN);
            if (!(cmd_faster || cmd_slower)) begin
                chk(0, "R2 decision timeout", waited, WIN);
                return;
            end
            if (k > 0) chk(waited == WIN, "R2 interval", waited, WIN);
            chk(!(cmd_faster && cmd_slower), "R2 one command", {cmd_faster, cmd_slower}, 1);
            es = exp_slower(prev_code, n, m);
            ecode = es ? ((prev_code > 0) ? prev_code - 1 : 0)
                       : ((prev_code < 8) ? prev_code + 1 : 8);
            if (es) begin
                chk(cmd_slower, "R3 direction", cmd_slower, 1);
                chk(speed_code == 4'(ecode), "R3 code", speed_code, ecode);
            end else begin
                chk(cmd_faster, "R4 direction", cmd_faster, 1);
                chk(speed_code == 4'(ecode), "R4 code", speed_code, ecode);
            end
            if (have_prev && es != prev_slow) rev = (rev < 4) ? rev + 1 : 4;
            else rev = 0;
            have_prev = 1;
            prev_slow = es;
            exp_hand = exp_hand | (rev == 4);
            chk(locked == (rev == 4), "R7 locked", locked, rev == 4);
            chk(handoff == exp_hand, "R8 handoff", handoff, exp_hand);
            prev_code = int'(speed_code);
        end
        lo = bracket_lo(n, m);
        if (lo >= 0 && lo < 8) begin
            chk(int'(speed_code) == lo || int'(speed_code) == lo + 1, "R5 bracket", speed_code, lo);
            chk(locked == 1'b1, "R5 lock", locked, 1);
        end else begin
            chk(int'(speed_code) == ((lo < 0) ? 0 : 8), "R9 hold", speed_code, (lo < 0) ? 0 : 8);
            chk(locked == 1'b0 && handoff == 1'b0, "R9 no lock", locked, 0);
        end
    endtask

    initial begin
        int n;
        int m;
        int tries;
        void'($urandom(32'd20240611));
        // Directed: target 40 MHz, bracket codes 6 and 7
        run_cfg(1, 1, 14);
        // R6: zero divisors behave as one
        run_cfg(0, 1, 14);
        chk(speed_code == 4'd6 || speed_code == 4'd7, "R6 feedback zero", speed_code, 6);
        run_cfg(1, 0, 14);
        chk(speed_code == 4'd6 || speed_code == 4'd7, "R6 reference zero", speed_code, 6);
        // R9: target above fastest, then below slowest
        run_cfg(8, 1, 12);
        run_cfg(1, 8, 12);
        // Constrained random in-range ratios
        for (int r = 0; r < 3; r++) begin
            int lo;
            tries = 0;
            do begin
                n = 1 + int'($urandom % 8);
                m = 1 + int'($urandom % 8);
                lo = bracket_lo(n, m);
                tries++;
            end while (!(margin_ok(n, m) && lo >= 0 && lo < 8) && tries < 500);
            if (tries >= 500) begin
                n = 1;
                m = 1;
            end
            run_cfg(n, m, 14);
        end
        finish_run();
    end

endmodule